// File: doc/BRIEF.md
# Linked-Descriptor Word-Copy Engine with Row/Stride Mode

This block is the data mover of a single DMA channel. Software places a chain of descriptors in memory and gives the engine the address of the first one. The engine reads that six-word descriptor, copies the data it describes one 32-bit word at a time, records completion, and then moves on to the descriptor whose address the current one holds. It stops when it reaches a null pointer or finds the channel disabled at a descriptor boundary.

Every memory access goes through one single-word master port. A request is held until the memory answers with ready. Each descriptor runs in one of two modes. Linear mode moves one flat byte count. Row mode splits the count into a number of rows and a row length, and after each row it applies a separate signed offset to the source and to the destination. Per-descriptor flags choose, for each side, whether the address steps forward and whether that side is skipped entirely. The fields of the descriptor being processed stay visible on output ports, so a register block can read them while the copy runs.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `end_flag` and `mem_req` are all 0.
- R2: A one-cycle `start` pulse while `chan_en` is 1 loads `start_addr` as the current descriptor address. `start` has no effect while `chan_en` is 0. The engine keeps fetching descriptors only while `chan_en` is 1 and the current address is non-zero, so a zero start address makes no memory access.
- R3: Every descriptor is six words at byte offsets +0, +4, +8, +12, +16 and +20, in this order: control, source address, destination address, length, stride, next address. After the fetch these values appear on `cur_info`, `cur_src`, `cur_dst`, `cur_len`, `cur_stride` and `cur_next`. `cur_src` and `cur_dst` then follow the live addresses.
- R4: With control bit 1 = 0 (linear mode), the length is a byte count, and ceil(length/4) words are moved. The source address steps by 4 per word when control bit 8 is 1, and the destination steps by 4 when control bit 4 is 1. A side whose bit is 0 keeps a fixed address.
- R5: With control bit 1 = 1 (row mode), length[29:16]+1 rows are moved, each of length[15:0] bytes. After each row, the signed value stride[15:0] is added to the source address and the signed value stride[31:16] to the destination address. This is in addition to the per-word step.
- R6: With control bit 11 = 1, no source read is made and the word written is zero.
- R7: With control bit 7 = 1, no destination write is made.
- R8: When a descriptor completes, `end_flag` is set. `irq` is also set if control bit 0 is 1. The next address is then copied into `cur_desc_addr`, and the chain continues from it.
- R9: Clearing `chan_en` in the middle of a descriptor does not cut that descriptor short. The chain stops before fetching the next descriptor, and `cur_desc_addr` holds the address of the next descriptor.
- R10: A `stat_clr` pulse clears `end_flag` and `irq`. A completion in the same cycle takes priority.
- R11: While `mem_req` is 1 and `mem_rdy` is 0, the request, address, write enable and write data hold steady. Each cycle with both signals at 1 completes exactly one access.
- R12: A zero byte count (linear mode) or a zero row length (row mode) completes the descriptor with no data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable, sampled at descriptor boundaries |
| start | input | 1 | Pulse that starts a chain |
| start_addr | input | AW | Address of the first descriptor |
| stat_clr | input | 1 | Pulse that clears `end_flag` and `irq` |
| busy | output | 1 | Engine not idle |
| end_flag | output | 1 | A descriptor has completed |
| irq | output | 1 | Interrupt from a completed descriptor |
| cur_desc_addr | output | AW | Current descriptor address |
| cur_info | output | DW | Control word |
| cur_src | output | AW | Live source address |
| cur_dst | output | AW | Live destination address |
| cur_len | output | DW | Length word |
| cur_stride | output | DW | Stride word |
| cur_next | output | AW | Next descriptor address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_rdy` |
| mem_rdy | input | 1 | Memory accepts the request this cycle |

## Verification
The copy function is tried with several descriptor patterns.

- A linear copy with both addresses stepping shows that words are ordered and counted correctly.
- An odd byte count into a fixed destination shows the rounding-up of the word count and a non-stepping side.
- Two row-mode descriptors, one with positive and one with negative row offsets, tell apart the per-word step, the per-row offset and the off-by-one in the row count.
- The skip-source and skip-destination patterns are checked through the memory contents and the access counts.
- Chained, disabled, zero-address and zero-length starts separate the descriptor-walking rules from the data path.

The memory model answers after 0, 1 or 2 wait cycles, so the request-hold rule is exercised with different latencies.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

   // control-word bit positions (software builds descriptors with them)
   localparam int CTL_IRQ_EN  = 0;
   localparam int CTL_ROWMODE = 1;
   localparam int CTL_DST_INC = 4;
   localparam int CTL_DST_SKP = 7;
   localparam int CTL_SRC_INC = 8;
   localparam int CTL_SRC_SKP = 11;

   // descriptor layout
   localparam int DESC_WORDS = 6;
   localparam int W_CTL      = 0;
   localparam int W_SRC      = 1;
   localparam int W_DST      = 2;
   localparam int W_LEN      = 3;
   localparam int W_STRIDE   = 4;
   localparam int W_NEXT     = 5;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOP,
      ST_FETCH,
      ST_SETUP,
      ST_RD,
      ST_WR,
      ST_ADV,
      ST_DONE
   } cdma_state_e;

endpackage

// File: rtl/cdma_desc_regs.sv
module cdma_desc_regs
   import cdma_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [2:0]    ld_idx,
   input  logic [DW-1:0] ld_word,
   input  logic          adr_upd,
   input  logic [AW-1:0] src_nxt,
   input  logic [AW-1:0] dst_nxt,
   output logic [DW-1:0] info,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [DW-1:0] len,
   output logic [DW-1:0] stride,
   output logic [AW-1:0] nxt
);

   logic [DW-1:0] words_q [DESC_WORDS];

   initial begin
      if (AW > DW) $fatal(1, "cdma_desc_regs: AW must not exceed DW");
   end

   for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
      if (g == W_SRC || g == W_DST) begin : g_live
         // address words are also advanced by the data path
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words_q[g] <= '0;
            else if (ld_en && ld_idx == 3'(g))
               words_q[g] <= ld_word;
            else if (adr_upd)
               words_q[g] <= DW'((g == W_SRC) ? src_nxt : dst_nxt);
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words_q[g] <= '0;
            else if (ld_en && ld_idx == 3'(g))
               words_q[g] <= ld_word;
         end
      end
   end

   assign info   = words_q[W_CTL];
   assign src    = words_q[W_SRC][AW-1:0];
   assign dst    = words_q[W_DST][AW-1:0];
   assign len    = words_q[W_LEN];
   assign stride = words_q[W_STRIDE];
   assign nxt    = words_q[W_NEXT][AW-1:0];

endmodule

// File: rtl/cdma_addr_step.sv
module cdma_addr_step #(
   parameter int AW   = 32,
   parameter int SW   = 16,
   parameter int BEAT = 4
) (
   input  logic [AW-1:0] addr,
   input  logic          inc,
   input  logic          row_end,
   input  logic [SW-1:0] stride,
   output logic [AW-1:0] nxt
);

   localparam int EXT = AW - SW;

   logic [AW-1:0] step_w;
   logic [AW-1:0] ofs_w;

   initial begin
      if (SW >= AW) $fatal(1, "cdma_addr_step: stride wider than address");
   end

   assign step_w = inc ? AW'(BEAT) : '0;
   assign ofs_w  = row_end ? {{EXT{stride[SW-1]}}, stride} : '0;
   assign nxt    = addr + step_w + ofs_w;

endmodule

// File: rtl/cdma_xfer_count.sv
module cdma_xfer_count #(
   parameter int LW   = 32,
   parameter int HW   = 16,
   parameter int RW   = 14,
   parameter int BEAT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          mode2d,
   input  logic [LW-1:0] len_word,
   input  logic          step,
   output logic          last_beat,
   output logic          last_row
);

   logic [LW-1:0] rem_q;
   logic [LW-1:0] row_len_q;
   logic [RW-1:0] rows_q;
   logic [LW-1:0] row_len_d;

   initial begin
      if (HW + RW > LW) $fatal(1, "cdma_xfer_count: row fields overflow length word");
   end

   assign row_len_d = mode2d ? LW'(len_word[HW-1:0]) : len_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q     <= '0;
         row_len_q <= '0;
         rows_q    <= '0;
      end else if (load) begin
         rem_q     <= row_len_d;
         row_len_q <= row_len_d;
         rows_q    <= mode2d ? len_word[HW+RW-1:HW] : '0;
      end else if (step) begin
         if (last_beat) begin
            if (!last_row) begin
               rows_q <= rows_q - 1'b1;
               rem_q  <= row_len_q;
            end
         end else begin
            rem_q <= rem_q - LW'(BEAT);
         end
      end
   end

   assign last_beat = (rem_q <= LW'(BEAT));
   assign last_row  = (rows_q == '0);

   // a word is only moved while bytes remain in the row (zero rows are skipped upstream)
   p_step_has_bytes_r12: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (rem_q != '0));

endmodule

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
   import cdma_pkg::*;
#(
   parameter int DW    = 32,
   parameter int AW    = 32,
   parameter int ROW_W = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chan_en,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic          stat_clr,
   output logic          busy,
   output logic          end_flag,
   output logic          irq,
   output logic [AW-1:0] cur_desc_addr,
   output logic [DW-1:0] cur_info,
   output logic [AW-1:0] cur_src,
   output logic [AW-1:0] cur_dst,
   output logic [DW-1:0] cur_len,
   output logic [DW-1:0] cur_stride,
   output logic [AW-1:0] cur_next,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_rdy
);

   localparam int BEAT = DW / 8;
   localparam int SW   = DW / 2;
   localparam int LASTW = DESC_WORDS - 1;

   initial begin
      if (DW != 32) $fatal(1, "chain_dma_engine: word width must be 32");
      if (SW + ROW_W > DW) $fatal(1, "chain_dma_engine: row field too wide");
   end

   cdma_state_e   state_q;
   logic [2:0]    idx_q;
   logic [AW-1:0] desc_q;
   logic [DW-1:0] data_q;
   logic          end_q;
   logic          irq_q;

   logic          ld_en;
   logic          adv;
   logic          mode2d;
   logic          row_zero;
   logic          last_beat;
   logic          last_row;
   logic [AW-1:0] cur_a  [2];
   logic          inc_a  [2];
   logic [SW-1:0] str_a  [2];
   logic [AW-1:0] nxt_a  [2];

   // ---------------- descriptor storage ----------------
   assign ld_en = (state_q == ST_FETCH) && mem_rdy;
   assign adv   = (state_q == ST_ADV);

   cdma_desc_regs #(.DW(DW), .AW(AW)) u_desc (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (ld_en),
      .ld_idx  (idx_q),
      .ld_word (mem_rdata),
      .adr_upd (adv),
      .src_nxt (nxt_a[0]),
      .dst_nxt (nxt_a[1]),
      .info    (cur_info),
      .src     (cur_src),
      .dst     (cur_dst),
      .len     (cur_len),
      .stride  (cur_stride),
      .nxt     (cur_next)
   );

   assign mode2d   = cur_info[CTL_ROWMODE];
   assign row_zero = mode2d ? (cur_len[SW-1:0] == '0) : (cur_len == '0);

   // ---------------- row / word counting ----------------
   cdma_xfer_count #(.LW(DW), .HW(SW), .RW(ROW_W), .BEAT(BEAT)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (state_q == ST_SETUP),
      .mode2d    (mode2d),
      .len_word  (cur_len),
      .step      (adv),
      .last_beat (last_beat),
      .last_row  (last_row)
   );

   // ---------------- address stepping, source (0) and destination (1) ----------------
   assign cur_a[0] = cur_src;
   assign cur_a[1] = cur_dst;
   assign inc_a[0] = cur_info[CTL_SRC_INC];
   assign inc_a[1] = cur_info[CTL_DST_INC];
   assign str_a[0] = cur_stride[SW-1:0];
   assign str_a[1] = cur_stride[DW-1:SW];

   for (genvar g = 0; g < 2; g++) begin : g_step
      cdma_addr_step #(.AW(AW), .SW(SW), .BEAT(BEAT)) u_step (
         .addr    (cur_a[g]),
         .inc     (inc_a[g]),
         .row_end (mode2d && last_beat),
         .stride  (str_a[g]),
         .nxt     (nxt_a[g])
      );
   end

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         desc_q  <= '0;
         data_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start && chan_en) begin
                  desc_q  <= start_addr;
                  state_q <= ST_LOOP;
               end
            end
            ST_LOOP: begin
               idx_q <= '0;
               if (chan_en && desc_q != '0) state_q <= ST_FETCH;
               else                         state_q <= ST_IDLE;
            end
            ST_FETCH: begin
               if (mem_rdy) begin
                  if (idx_q == 3'(LASTW)) state_q <= ST_SETUP;
                  else                    idx_q   <= idx_q + 1'b1;
               end
            end
            ST_SETUP: begin
               state_q <= row_zero ? ST_DONE : ST_RD;
            end
            ST_RD: begin
               if (cur_info[CTL_SRC_SKP]) begin
                  data_q  <= '0;
                  state_q <= ST_WR;
               end else if (mem_rdy) begin
                  data_q  <= mem_rdata;
                  state_q <= ST_WR;
               end
            end
            ST_WR: begin
               if (cur_info[CTL_DST_SKP] || mem_rdy) state_q <= ST_ADV;
            end
            ST_ADV: begin
               state_q <= (last_beat && last_row) ? ST_DONE : ST_RD;
            end
            ST_DONE: begin
               desc_q  <= cur_next;
               state_q <= ST_LOOP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // completion status: a set in the same cycle overrides a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         end_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (stat_clr) begin
            end_q <= 1'b0;
            irq_q <= 1'b0;
         end
         if (state_q == ST_DONE) begin
            end_q <= 1'b1;
            if (cur_info[CTL_IRQ_EN]) irq_q <= 1'b1;
         end
      end
   end

   // ---------------- memory port ----------------
   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = '0;
      case (state_q)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = desc_q + AW'(idx_q) * AW'(BEAT);
         end
         ST_RD: begin
            mem_req  = !cur_info[CTL_SRC_SKP];
            mem_addr = cur_src;
         end
         ST_WR: begin
            mem_req  = !cur_info[CTL_DST_SKP];
            mem_we   = 1'b1;
            mem_addr = cur_dst;
         end
         default: ;
      endcase
   end

   assign mem_wdata     = data_q;
   assign busy          = (state_q != ST_IDLE);
   assign end_flag      = end_q;
   assign irq           = irq_q;
   assign cur_desc_addr = desc_q;

   // ---------------- assertions ----------------
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   p_no_write_skipped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !cur_info[CTL_DST_SKP]);

   p_zero_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && cur_info[CTL_SRC_SKP]) |-> (mem_wdata == '0));

   p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start && chan_en));

   p_stop_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LOOP && !chan_en) |=> !busy);

   p_irq_has_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> end_flag);

endmodule

// File: tb/sim_chain_dma_engine.sv
module sim_chain_dma_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chan_en = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_addr = '0;
   logic        stat_clr = 1'b0;
   logic        busy, end_flag, irq;
   logic [31:0] cur_desc_addr, cur_info, cur_src, cur_dst, cur_len, cur_stride, cur_next;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_rdy = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   int n_rd  = 0;
   int n_wr  = 0;
   int lat   = 0;
   int wcnt  = 0;
   logic [31:0] mem [0:1023];

   always #2 clk = ~clk;

   chain_dma_engine u0 (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start(start), .start_addr(start_addr),
      .stat_clr(stat_clr), .busy(busy), .end_flag(end_flag), .irq(irq),
      .cur_desc_addr(cur_desc_addr), .cur_info(cur_info), .cur_src(cur_src), .cur_dst(cur_dst),
      .cur_len(cur_len), .cur_stride(cur_stride), .cur_next(cur_next),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_rdy(mem_rdy)
   );

   // memory model: answers on the falling edge after lat waiting cycles
   always @(negedge clk) begin
      if (mem_rdy) begin
         mem_rdy = 1'b0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            wcnt = 0;
            if (mem_we) begin
               mem[mem_addr[11:2]] = mem_wdata;
               n_wr++;
            end else begin
               mem_rdata = mem[mem_addr[11:2]];
               n_rd++;
            end
            mem_rdy = 1'b1;
         end else begin
            wcnt++;
         end
      end
   end

   function automatic logic [31:0] pat(input logic [31:0] a);
      return 32'hA500_0000 + (a >> 2);
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic put_desc(input logic [31:0] at, input logic [31:0] ctl, input logic [31:0] s,
                           input logic [31:0] d, input logic [31:0] l, input logic [31:0] st,
                           input logic [31:0] nx);
      mem[at[11:2]]     = ctl;
      mem[at[11:2] + 1] = s;
      mem[at[11:2] + 2] = d;
      mem[at[11:2] + 3] = l;
      mem[at[11:2] + 4] = st;
      mem[at[11:2] + 5] = nx;
   endtask

   task automatic fill(input logic [31:0] at, input int words, input logic [31:0] v);
      for (int i = 0; i < words; i++) mem[at[11:2] + i] = v;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 4000) begin
         @(negedge clk);
         n++;
      end
      if (busy) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R2 engine still busy: actual 1 expected 0");
      end
   endtask

   task automatic run(input logic [31:0] a);
      @(negedge clk);
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      n_rd = 0;
      n_wr = 0;
      start = 1'b1;
      start_addr = a;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "busy", 32'(busy), 0);
      chk("R1", "irq", 32'(irq), 0);
      chk("R1", "end_flag", 32'(end_flag), 0);
      chk("R1", "mem_req", 32'(mem_req), 0);
   endtask

   task automatic t_linear();
      lat = 0;
      put_desc(32'h100, 32'h111, 32'h400, 32'h800, 16, 0, 0);
      fill(32'h800, 8, 0);
      run(32'h100);
      for (int i = 0; i < 4; i++) chk("R4", "linear word", mem[10'h200 + i], pat(32'h400 + 4 * i));
      chk("R11", "write count", n_wr, 4);
      chk("R4", "word after end", mem[10'h204], 0);
      chk("R8", "end_flag", 32'(end_flag), 1);
      chk("R8", "irq", 32'(irq), 1);
      chk("R3", "cur_info", cur_info, 32'h111);
      chk("R3", "cur_len", cur_len, 16);
      chk("R3", "cur_src live", cur_src, 32'h410);
      chk("R3", "cur_dst live", cur_dst, 32'h810);
      chk("R8", "desc addr follows next", cur_desc_addr, 0);
   endtask

   task automatic t_fixed_dst();
      lat = 2;
      put_desc(32'h120, 32'h100, 32'h400, 32'h900, 10, 0, 0);
      fill(32'h900, 2, 0);
      run(32'h120);
      chk("R4", "fixed dst holds last word", mem[10'h240], pat(32'h408));
      chk("R4", "fixed dst neighbour", mem[10'h241], 0);
      chk("R4", "odd length word count", n_wr, 3);
      chk("R8", "end without irq enable", 32'(end_flag), 1);
      chk("R8", "irq stays low", 32'(irq), 0);
   endtask

   task automatic t_rows_pos();
      lat = 1;
      put_desc(32'h140, 32'h112, 32'h400, 32'hA00, (32'd2 << 16) | 32'd8, 32'h0010_0008, 0);
      fill(32'hA00, 20, 0);
      run(32'h140);
      for (int r = 0; r < 3; r++)
         for (int c = 0; c < 2; c++)
            chk("R5", "row word", mem[(32'hA00 + 24 * r + 4 * c) >> 2], pat(32'h400 + 16 * r + 4 * c));
      chk("R5", "row count plus one", n_wr, 6);
      chk("R5", "src after rows", cur_src, 32'h430);
      chk("R5", "dst after rows", cur_dst, 32'hA48);
   endtask

   task automatic t_rows_neg();
      lat = 0;
      put_desc(32'h160, 32'h112, 32'h440, 32'hB00, (32'd1 << 16) | 32'd8, 32'h0000_FFF0, 0);
      fill(32'hB00, 4, 0);
      run(32'h160);
      chk("R5", "neg stride w0", mem[10'h2C0], pat(32'h440));
      chk("R5", "neg stride w1", mem[10'h2C1], pat(32'h444));
      chk("R5", "neg stride w2", mem[10'h2C2], pat(32'h438));
      chk("R5", "neg stride w3", mem[10'h2C3], pat(32'h43C));
   endtask

   task automatic t_src_skip();
      lat = 1;
      put_desc(32'h180, 32'h810, 32'h400, 32'hC00, 8, 0, 0);
      fill(32'hC00, 2, 32'hFFFF_FFFF);
      run(32'h180);
      chk("R6", "zero word 0", mem[10'h300], 0);
      chk("R6", "zero word 1", mem[10'h301], 0);
      chk("R6", "reads only fetch", n_rd, 6);
   endtask

   task automatic t_dst_skip();
      lat = 0;
      put_desc(32'h1A0, 32'h190, 32'h400, 32'hC40, 8, 0, 0);
      fill(32'hC40, 2, 32'h1234_5678);
      run(32'h1A0);
      chk("R7", "no writes", n_wr, 0);
      chk("R7", "dst untouched", mem[10'h310], 32'h1234_5678);
      chk("R7", "source still read", n_rd, 8);
      chk("R7", "dst address stepped", cur_dst, 32'hC48);
   endtask

   task automatic t_chain();
      lat = 1;
      put_desc(32'h1C0, 32'h110, 32'h480, 32'hD00, 8, 0, 32'h1E0);
      put_desc(32'h1E0, 32'h111, 32'h4C0, 32'hD40, 4, 0, 0);
      fill(32'hD00, 20, 0);
      run(32'h1C0);
      chk("R8", "first desc w0", mem[10'h340], pat(32'h480));
      chk("R8", "first desc w1", mem[10'h341], pat(32'h484));
      chk("R8", "second desc w0", mem[10'h350], pat(32'h4C0));
      chk("R3", "fetches of both descs", n_rd, 15);
      chk("R8", "irq from second", 32'(irq), 1);
      chk("R3", "cur_info of last", cur_info, 32'h111);
      chk("R2", "stops at null", cur_desc_addr, 0);
   endtask

   task automatic t_gated();
      chan_en = 1'b0;
      put_desc(32'h200, 32'h111, 32'h400, 32'hE00, 4, 0, 0);
      run(32'h200);
      chk("R2", "disabled start busy", 32'(busy), 0);
      chk("R2", "disabled start reads", n_rd, 0);
      chk("R2", "disabled start end", 32'(end_flag), 0);
      chan_en = 1'b1;
      run(32'h0);
      chk("R2", "null start reads", n_rd, 0);
      chk("R2", "null start end", 32'(end_flag), 0);
   endtask

   task automatic t_stop_mid();
      int n = 0;
      lat = 1;
      put_desc(32'h220, 32'h110, 32'h400, 32'hE00, 32, 0, 32'h240);
      put_desc(32'h240, 32'h111, 32'h400, 32'hE80, 4, 0, 0);
      fill(32'hE00, 40, 0);
      @(negedge clk);
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      n_wr = 0;
      start = 1'b1;
      start_addr = 32'h220;
      @(negedge clk);
      start = 1'b0;
      while (n_wr < 1 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chan_en = 1'b0;
      wait_idle();
      chk("R9", "whole desc moved", n_wr, 8);
      chk("R9", "last word of desc", mem[10'h387], pat(32'h41C));
      chk("R9", "next desc not run", mem[10'h3A0], 0);
      chk("R9", "desc addr parked", cur_desc_addr, 32'h240);
      chk("R9", "end_flag", 32'(end_flag), 1);
      chan_en = 1'b1;
   endtask

   task automatic t_zero_len();
      lat = 0;
      put_desc(32'h260, 32'h001, 32'h400, 32'hE00, 0, 0, 0);
      run(32'h260);
      chk("R12", "zero len reads", n_rd, 6);
      chk("R12", "zero len writes", n_wr, 0);
      chk("R12", "zero len end", 32'(end_flag), 1);
      chk("R8", "zero len irq", 32'(irq), 1);
   endtask

   task automatic t_clear();
      @(negedge clk);
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      chk("R10", "end cleared", 32'(end_flag), 0);
      chk("R10", "irq cleared", 32'(irq), 0);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i) << 2);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      chan_en = 1'b1;
      @(negedge clk);
      t_reset();
      t_linear();
      t_fixed_dst();
      t_rows_pos();
      t_rows_neg();
      t_src_skip();
      t_dst_skip();
      t_chain();
      t_gated();
      t_stop_mid();
      t_zero_len();
      t_clear();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule